// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block measures how long an external digital signal stays in a state. A 16-bit up-counter advances on ticks of a selectable count source. The source is the core clock, the clock divided by eight, the clock divided by a programmable even ratio, or a slow auxiliary clock input. Each time the measured input shows a valid edge, the running count is latched into a capture register and the counter restarts from zero. The time between two valid edges can then be read back in ticks.

In period mode only one polarity of edge is valid, so each capture spans one full cycle of the input. In width mode every transition is valid, so the captures alternate between the high time and the low time. An interrupt pulse marks every capture except the first one after counting starts. An interrupt pulse also marks a counter wrap, which sets a sticky overflow flag in the mode register. Software can clear that flag only under a narrow condition: counting must be running, and the counter must have ticked at least once since the wrap.

Top module: `pwcap_timer`

## Requirements
- R1: After reset, the capture register reads 0, the mode register reads 0 (overflow flag included), the run bit reads 0 and `irq` is low.
- R2: Mode bits [3:2] pick the count source: 0 = every clock, 1 = every 8th clock, 2 = every 2n-th clock where n is mode bits [7:4] and n = 0 means every clock, 3 = each rising edge of `slowIn`.
- R3: In period mode (mode bit 0 = 0), only the edge chosen by mode bit 1 is valid (0 = rising, 1 = falling). Edges of the other polarity have no effect on the capture.
- R4: In width mode (mode bit 0 = 1), both polarities are valid. A capture taken on a falling edge holds the high time, and one taken on a rising edge holds the low time.
- R5: On a valid edge, the capture register takes the count and the counter restarts at 0 in the same tick. For edges spaced T ticks apart, the capture reads T-1.
- R6: The first valid edge after the run bit is set raises no interrupt. Each later valid edge raises `irq` for exactly one clock cycle.
- R7: While the run bit (address 0, bit 0) is 0, the counter holds its value and changes on `measIn` are ignored. Stopped time is not counted.
- R8: When the counter wraps from all ones to zero with no valid edge in that tick, the overflow flag (mode register bit 8) is set and `irq` pulses in the same cycle.
- R9: A write to the mode register clears the overflow flag only when the run bit is 1 and at least one count tick has passed since the flag was set. In every other case the flag stays set.
- R10: A write to the timer address (2) changes neither the capture register nor the running counter.
- R11: Address 0 reads back the run bit, address 1 reads back mode bits [7:0] as written plus the overflow flag in bit 8, and address 2 reads the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for reads and writes |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for `regAddr` (combinational) |
| measIn | input | 1 | Asynchronous signal being measured |
| slowIn | input | 1 | Asynchronous slow clock used as count source 3 |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions assume the following about the inputs:
- `measIn` and `slowIn` are slow compared with the core clock.
- Register writes arrive as isolated single-cycle strobes.
- Reset is held long enough to clear the synchroniser stages.

The stimulus respects these limits. It changes both asynchronous inputs only on falling clock edges. It spaces every pulse to a whole multiple of the selected tick period, which fixes the phase between edges and ticks and makes the captured counts exact. It issues each write for a single cycle, and it changes the measured input while stopped only when the run bit is known to be low.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

  localparam int DIV_W  = 4;
  localparam int MODE_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_CAP  = 2'd2;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_DIV8 = 2'd1,
    SRC_DIVN = 2'd2,
    SRC_SLOW = 2'd3
  } srcSel_e;

  // Bit 0 width mode, bit 1 falling polarity, bits 3:2 source, bits 7:4 ratio
  typedef struct packed {
    logic [DIV_W-1:0] div;
    srcSel_e          src;
    logic             fall;
    logic             wid;
  } modeReg_t;

  // Strobes handed from control to the datapath
  typedef struct packed {
    logic tick;
    logic capture;
  } cntStb_t;

endpackage

// File: rtl/pwcap_ctrl.sv
module pwcap_ctrl
  import pwcap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              measIn,
  input  logic              slowIn,
  input  logic              atMax,
  output cntStb_t           stb,
  output logic              runBit,
  output modeReg_t          modeReg,
  output logic              ovfFlag,
  output logic              irq
);

  localparam int PRE_W = DIV_W + 2;

  logic              unusedWr;
  logic              modeWr;
  logic [SYNC_N-1:0] measSh;
  logic [SYNC_N:0]   slowSh;
  logic              measSync;
  logic              measSamp;
  logic              slowRise;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLimit;
  logic              preHit;
  logic              tick;
  logic              edgeHit;
  logic              validEdge;
  logic              ovfEvt;
  logic              seenEdge;
  logic              tickSinceOvf;

  assign unusedWr = ^wrData[DATA_W-1:MODE_W];
  assign modeWr   = wrEn && (regAddr == ADDR_MODE);

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      runBit  <= 1'b0;
      modeReg <= '0;
    end else if (wrEn) begin
      if (regAddr == ADDR_CTRL) runBit  <= wrData[0];
      if (regAddr == ADDR_MODE) modeReg <= modeReg_t'(wrData[MODE_W-1:0]);
    end
  end

  // synchronisers for both asynchronous inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      measSh <= '0;
      slowSh <= '0;
    end else begin
      measSh <= {measSh[SYNC_N-2:0], measIn};
      slowSh <= {slowSh[SYNC_N-1:0], slowIn};
    end
  end
  assign measSync = measSh[SYNC_N-1];
  assign slowRise = slowSh[SYNC_N-1] & ~slowSh[SYNC_N];

  // prescaler
  always_comb begin
    unique case (modeReg.src)
      SRC_DIV8: preLimit = PRE_W'(8);
      SRC_DIVN: preLimit = (modeReg.div == '0) ? PRE_W'(1)
                                               : PRE_W'({modeReg.div, 1'b0});
      default:  preLimit = PRE_W'(1);
    endcase
  end
  assign preHit = (preCnt >= preLimit - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !runBit || modeReg.src == SRC_SLOW) preCnt <= '0;
    else if (preHit)                               preCnt <= '0;
    else                                           preCnt <= preCnt + PRE_W'(1);
  end

  assign tick = runBit && ((modeReg.src == SRC_SLOW) ? slowRise : preHit);

  // edge detection on tick boundaries
  always_comb begin
    if (modeReg.wid)       edgeHit = measSync ^ measSamp;
    else if (modeReg.fall) edgeHit = ~measSync & measSamp;
    else                   edgeHit = measSync & ~measSamp;
  end
  assign validEdge = tick && edgeHit;
  assign ovfEvt    = tick && !validEdge && atMax;

  always_ff @(posedge clk) begin
    if (rst)                  measSamp <= 1'b0;
    else if (!runBit || tick) measSamp <= measSync;
  end

  always_ff @(posedge clk) begin
    if (rst || !runBit) seenEdge <= 1'b0;
    else if (validEdge) seenEdge <= 1'b1;
  end

  // overflow flag and its clear qualifier
  always_ff @(posedge clk) begin
    if (rst) begin
      ovfFlag      <= 1'b0;
      tickSinceOvf <= 1'b0;
    end else begin
      if (ovfEvt)                               ovfFlag <= 1'b1;
      else if (modeWr && runBit && tickSinceOvf) ovfFlag <= 1'b0;
      if (ovfEvt)    tickSinceOvf <= 1'b0;
      else if (tick) tickSinceOvf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (validEdge && seenEdge) || ovfEvt;
  end

  assign stb.tick    = tick;
  assign stb.capture = validEdge;

  // R6
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick));

  // R8
  ovf_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovfFlag) |-> irq);

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovfFlag) |-> ($past(runBit) && $past(modeWr)));

endmodule

// File: rtl/pwcap_dpath.sv
module pwcap_dpath
  import pwcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStb_t          stb,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output logic             atMax
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      capVal <= '0;
    end else if (stb.tick) begin
      if (stb.capture) begin
        capVal <= count;
        count  <= '0;
      end else begin
        count <= count + CNT_W'(1);
      end
    end
  end

  assign atMax = &count;

endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              measIn,
  input  logic              slowIn,
  output logic              irq
);

  cntStb_t          stb;
  logic             runBit;
  modeReg_t         modeReg;
  logic             ovfFlag;
  logic             atMax;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capVal;

  pwcap_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .measIn(measIn), .slowIn(slowIn), .atMax(atMax), .stb(stb),
    .runBit(runBit), .modeReg(modeReg), .ovfFlag(ovfFlag), .irq(irq)
  );

  pwcap_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk(clk), .rst(rst), .stb(stb), .count(count), .capVal(capVal),
    .atMax(atMax)
  );

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      ADDR_CTRL: rdData[0] = runBit;
      ADDR_MODE: rdData[MODE_W:0] = {ovfFlag, modeReg};
      ADDR_CAP:  rdData[CNT_W-1:0] = capVal;
      default:   rdData = '0;
    endcase
  end

  // R5
  capture_restart_chk: assert property (@(posedge clk) disable iff (rst)
    stb.capture |=> (count == '0));

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !runBit |=> $stable(count));

  // R10
  timer_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == ADDR_CAP && !stb.capture) |=> $stable(capVal));

endmodule

// File: tb/pwcap_timer_test.sv
module pwcap_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        measIn = 1'b0;
  logic        slowIn = 1'b0;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;
  int irqCnt   = 0;
  int cycCnt   = 0;

  pwcap_timer uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .measIn(measIn), .slowIn(slowIn), .irq(irq)
  );

  always #5 clk = ~clk;

  // slow source: period of 10 core clocks
  always begin
    repeat (5) @(negedge clk);
    slowIn = ~slowIn;
  end

  always @(negedge clk) begin
    if (!rst && irq) irqCnt++;
  end

  always @(negedge clk) begin
    cycCnt++;
    if (cycCnt > 150000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer than 150000", cycCnt);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  src;
    logic [3:0]  div;
    logic        wid;
    logic        fall;
    logic [15:0] hi;
    logic [15:0] lo;
    logic        endHi;
    logic [15:0] expv;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 4'd0, 1'b0, 1'b0, 16'd12, 16'd20, 1'b0, 16'd31},
    '{2'd0, 4'd0, 1'b0, 1'b1, 16'd7,  16'd18, 1'b0, 16'd24},
    '{2'd1, 4'd0, 1'b0, 1'b0, 16'd16, 16'd24, 1'b0, 16'd4},
    '{2'd2, 4'd3, 1'b0, 1'b0, 16'd12, 16'd24, 1'b0, 16'd5},
    '{2'd2, 4'd0, 1'b0, 1'b0, 16'd5,  16'd6,  1'b1, 16'd10},
    '{2'd3, 4'd0, 1'b0, 1'b0, 16'd30, 16'd50, 1'b0, 16'd7},
    '{2'd0, 4'd0, 1'b1, 1'b0, 16'd9,  16'd21, 1'b0, 16'd8},
    '{2'd0, 4'd0, 1'b1, 1'b0, 16'd9,  16'd21, 1'b1, 16'd20},
    '{2'd1, 4'd0, 1'b1, 1'b0, 16'd24, 16'd40, 1'b1, 16'd4}
  };

  function automatic logic [15:0] modeWord(logic [1:0] src, logic [3:0] div,
                                           logic wid, logic fall);
    return {8'd0, div, src, fall, wid};
  endfunction

  task automatic check(string req, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    regAddr = a;
    wrData  = d;
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  logic [15:0] val;
  logic [15:0] mw;
  int          irqBase;
  bit          found;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, val); check("R1 capture after reset", val, 0);
    rd(2'd1, val); check("R1 mode after reset", val, 0);
    rd(2'd0, val); check("R1 run bit after reset", val, 0);
    check("R1 irq after reset", irq, 0);

    // table of sources, polarities and widths
    for (int i = 0; i < NVEC; i++) begin
      string lbl;
      vec_t v;
      v = VECS[i];
      lbl = v.wid ? "R4 width mode" : (v.fall ? "R3 falling polarity" : "R2 count source");
      wr(2'd0, 16'd0);
      measIn = 1'b0;
      mw = modeWord(v.src, v.div, v.wid, v.fall);
      wr(2'd1, mw);
      rd(2'd1, val);
      check($sformatf("R11 mode readback vec%0d", i), val & 16'h00FF, mw);
      repeat (5) @(negedge clk);
      wr(2'd0, 16'd1);
      for (int k = 0; k < 4; k++) begin
        measIn = 1'b1;
        repeat (v.hi) @(negedge clk);
        measIn = 1'b0;
        repeat (v.lo) @(negedge clk);
      end
      measIn = v.endHi;
      repeat (60) @(negedge clk);
      rd(2'd2, val);
      check($sformatf("R5 %s vec%0d", lbl, i), val, v.expv);
      wr(2'd0, 16'd0);
      measIn = 1'b0;
      repeat (5) @(negedge clk);
    end

    // R6 first edge after start raises no interrupt
    mw = modeWord(2'd0, 4'd0, 1'b0, 1'b0);
    wr(2'd1, mw);
    wr(2'd0, 16'd1);
    repeat (3) @(negedge clk);
    irqBase = irqCnt;
    measIn = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 no irq on first edge", irqCnt - irqBase, 0);
    measIn = 1'b0;
    repeat (10) @(negedge clk);
    measIn = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 one irq on second edge", irqCnt - irqBase, 1);

    // R10 timer write ignored
    rd(2'd2, val);
    check("R10 capture before timer write", val, 19);
    wr(2'd2, 16'hBEEF);
    rd(2'd2, val);
    check("R10 capture after timer write", val, 19);
    measIn = 1'b0;
    repeat (9) @(negedge clk);
    measIn = 1'b1;
    repeat (10) @(negedge clk);
    rd(2'd2, val);
    check("R10 counter undisturbed by timer write", val, 19);

    // R7 stopped time and input edges are not counted
    wr(2'd0, 16'd0);
    measIn = 1'b0;
    repeat (3) @(negedge clk);
    measIn = 1'b1;
    repeat (3) @(negedge clk);
    measIn = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd0, 16'd1);
    repeat (29) @(negedge clk);
    measIn = 1'b1;
    repeat (20) @(negedge clk);
    rd(2'd2, val);
    check("R7 stopped interval excluded", val, 39);

    // R8 overflow and R9 clear rule
    wr(2'd0, 16'd0);
    measIn = 1'b0;
    repeat (5) @(negedge clk);
    wr(2'd0, 16'd1);
    found = 1'b0;
    for (int k = 0; k < 70000 && !found; k++) begin
      @(negedge clk);
      if (irq) found = 1'b1;
    end
    check("R8 overflow irq seen", found, 1);
    rd(2'd1, val);
    check("R8 overflow flag set", val[8], 1);
    wr(2'd1, mw);
    rd(2'd1, val);
    check("R9 flag kept without tick since set", val[8], 1);
    wr(2'd0, 16'd0);
    wr(2'd1, mw);
    rd(2'd1, val);
    check("R9 flag kept while stopped", val[8], 1);
    wr(2'd0, 16'd1);
    repeat (3) @(negedge clk);
    wr(2'd1, mw);
    rd(2'd1, val);
    check("R9 flag cleared when running", val[8], 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule